// File: doc/BRIEF.md
# Interrupt Enable and Fast/Normal Request Router

This block gathers a set of interrupt request lines, lets software mask each line and decide whether it belongs to the fast interrupt or to the normal interrupt, and drives one combined request output of each kind. Every line is the OR of a hardware request pin and a software request bit with the same index. The software request vector arrives as an input; the registers that produce it, vector addressing and priority are handled elsewhere.

Software reaches the block through a simple word-wide register bus: an address, a write strobe, write data and combinational read data. The enable mask is never rewritten as a whole. One offset only sets mask bits and another, which cannot be read, only clears them, so two software agents can change different lines without a read-modify-write race. A read/write select word steers each enabled line to the fast output (bit 1) or the normal output (bit 0).

Request inputs are level-sensitive. The raw view and both outputs are registered, so a change on a request or on the mask shows up at the outputs after one clock edge.

Top module: `irq_route_top`

## Requirements
- R1: Offset 0x08 reads, for each line i, bit i = 1 if hw_req_i[i] or sw_req_i[i] was high at the last clock edge, whatever the enable mask holds.
- R2: Offset 0x10 reads the enable mask, bit i = 1 when line i is enabled.
- R3: A write to offset 0x10 sets every mask bit whose data bit is 1; mask bits whose data bit is 0 keep their value.
- R4: A write to offset 0x14 clears every mask bit whose data bit is 1 and leaves the others; reading offset 0x14 returns zero.
- R5: Offset 0x0C is a read/write select word; bit i = 1 routes line i to fiq_o, bit i = 0 routes it to irq_o.
- R6: After reset the enable mask and the select word are all zeros and fiq_o and irq_o are low.
- R7: fiq_o is the OR over all lines of (request AND enable AND select); irq_o is the OR over all lines of (request AND enable AND NOT select).
- R8: fiq_o and irq_o change one clock edge after the request inputs or the mask change, not in the same cycle.
- R9: Reads of any offset other than 0x08, 0x0C and 0x10 return zero, and writes to them change neither the mask nor the select word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_req_i | input | 32 | Hardware request lines, level-sensitive |
| sw_req_i | input | 32 | Software request vector, OR-ed per line with hw_req_i |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wr_i | input | 1 | Write strobe for one cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| fiq_o | output | 1 | Combined fast interrupt request, registered |
| irq_o | output | 1 | Combined normal interrupt request, registered |

## Verification
Routing is tried with a single enabled line on each output, with one enabled line on each side at once, with an alternating select against both alternating request halves (telling fast from normal lines apart over the whole word), and with requests that are present but masked. Requests come from the hardware pins and from the software vector separately, so the OR per line is seen on both paths. Mask writes mix ones and zeros so that set-only and clear-only behaviour is told apart from a plain overwrite, and writes to unmapped offsets are followed by reads of the mask and select words. Outputs are sampled both before and after the edge that follows a change, which separates the one-cycle latency from a combinational path.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    // Register byte offsets; software depends on these values.
    localparam int unsigned OFF_RAW    = 32'h08;
    localparam int unsigned OFF_SELECT = 32'h0C;
    localparam int unsigned OFF_ENABLE = 32'h10;
    localparam int unsigned OFF_CLEAR  = 32'h14;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_RAW,
        REG_SELECT,
        REG_ENABLE,
        REG_CLEAR
    } reg_id_e;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_route_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    output reg_id_e           reg_o,
    output logic              we_set_o,
    output logic              we_clr_o,
    output logic              we_sel_o
);

    always_comb begin
        reg_o = REG_NONE;
        if (addr_i == ADDR_W'(OFF_RAW))    reg_o = REG_RAW;
        if (addr_i == ADDR_W'(OFF_SELECT)) reg_o = REG_SELECT;
        if (addr_i == ADDR_W'(OFF_ENABLE)) reg_o = REG_ENABLE;
        if (addr_i == ADDR_W'(OFF_CLEAR))  reg_o = REG_CLEAR;
    end

    assign we_set_o = wr_i && (reg_o == REG_ENABLE);
    assign we_clr_o = wr_i && (reg_o == REG_CLEAR);
    assign we_sel_o = wr_i && (reg_o == REG_SELECT);

endmodule

// File: rtl/irq_req_sampler.sv
module irq_req_sampler #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hw_i,
    input  logic [N-1:0] sw_i,
    output logic [N-1:0] req_now_o,
    output logic [N-1:0] req_q_o
);

    typedef struct packed {
        logic [N-1:0] req;
    } samp_t;

    samp_t s_d, s_q;

    always_comb begin
        req_now_o = hw_i | sw_i;
        s_d       = s_q;
        s_d.req   = req_now_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_q_o = s_q.req;

endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         sel_we_i,
    input  logic [N-1:0] sel_wdata_i,
    output logic [N-1:0] en_o,
    output logic [N-1:0] route_o
);

    typedef struct packed {
        logic [N-1:0] en;
        logic [N-1:0] route;
    } mask_t;

    mask_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        // clear has precedence over set on the same bit
        m_d.en = (m_q.en | set_i) & ~clr_i;
        if (sel_we_i) m_d.route = sel_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign en_o    = m_q.en;
    assign route_o = m_q.route;

    assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> ((m_q.en & $past(clr_i)) == '0));

    assert_set_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & ~clr_i)) |=> ((m_q.en & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));

    assert_route_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_we_i |=> $stable(m_q.route));

endmodule

// File: rtl/irq_route_combine.sv
module irq_route_combine #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] route_i,
    output logic         fiq_o,
    output logic         irq_o
);

    typedef struct packed {
        logic fiq;
        logic irq;
    } out_t;

    out_t o_d, o_q;
    logic [N-1:0] fast_hit, norm_hit;

    for (genvar i = 0; i < N; i++) begin : g_line
        assign fast_hit[i] = req_i[i] & en_i[i] &  route_i[i];
        assign norm_hit[i] = req_i[i] & en_i[i] & ~route_i[i];
    end

    always_comb begin
        o_d     = o_q;
        o_d.fiq = |fast_hit;
        o_d.irq = |norm_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign fiq_o = o_q.fiq;
    assign irq_o = o_q.irq;

    assert_fiq_needs_fast_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(o_q.fiq) |-> $past(|(en_i & route_i & req_i)));

    assert_irq_needs_norm_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(o_q.irq) |-> $past(|(en_i & ~route_i & req_i)));

    assert_no_request_no_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) |=> (!o_q.fiq && !o_q.irq));

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
    import irq_route_pkg::*;
#(
    parameter int N      = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      hw_req_i,
    input  logic [N-1:0]      sw_req_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [N-1:0]      bus_wdata_i,
    output logic [N-1:0]      bus_rdata_o,
    output logic              fiq_o,
    output logic              irq_o
);

    reg_id_e      reg_id;
    logic         we_set, we_clr, we_sel;
    logic [N-1:0] req_now, req_q;
    logic [N-1:0] en, route;
    logic [N-1:0] set_vec, clr_vec;

    irq_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i   (bus_addr_i),
        .wr_i     (bus_wr_i),
        .reg_o    (reg_id),
        .we_set_o (we_set),
        .we_clr_o (we_clr),
        .we_sel_o (we_sel)
    );

    irq_req_sampler #(.N(N)) u_samp (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_i      (hw_req_i),
        .sw_i      (sw_req_i),
        .req_now_o (req_now),
        .req_q_o   (req_q)
    );

    assign set_vec = we_set ? bus_wdata_i : '0;
    assign clr_vec = we_clr ? bus_wdata_i : '0;

    irq_mask_regs #(.N(N)) u_mask (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (set_vec),
        .clr_i       (clr_vec),
        .sel_we_i    (we_sel),
        .sel_wdata_i (bus_wdata_i),
        .en_o        (en),
        .route_o     (route)
    );

    irq_route_combine #(.N(N)) u_comb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_now),
        .en_i    (en),
        .route_i (route),
        .fiq_o   (fiq_o),
        .irq_o   (irq_o)
    );

    always_comb begin
        unique case (reg_id)
            REG_RAW:    bus_rdata_o = req_q;
            REG_SELECT: bus_rdata_o = route;
            REG_ENABLE: bus_rdata_o = en;
            default:    bus_rdata_o = '0;
        endcase
    end

    assert_clear_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == ADDR_W'(OFF_CLEAR)) |-> (bus_rdata_o == '0));

    assert_unmapped_write_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && reg_id == REG_NONE) |=> ($stable(en) && $stable(route)));

endmodule

// File: tb/irq_route_top_tb.sv
module irq_route_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  hw_req = '0, sw_req = '0;
    logic [7:0]    addr = '0;
    logic          wr = 1'b0;
    logic [N-1:0]  wdata = '0;
    logic [N-1:0]  rdata;
    logic          fiq, irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_route_top u_dut (
        .clk(clk), .rst_n(rst_n), .hw_req_i(hw_req), .sw_req_i(sw_req),
        .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .fiq_o(fiq), .irq_o(irq)
    );

    typedef struct {
        string       tag;
        logic        chk_rd;
        logic [N-1:0] rd;
        logic        fiq;
        logic        irq;
    } item_t;

    item_t q[$];
    int checks = 0, errors = 0;

    // reference model, built from the requirements
    logic [N-1:0] en_m = '0, sel_m = '0;
    logic         fiq_m = 1'b0, irq_m = 1'b0;
    logic [N-1:0] pend_set = '0, pend_clr = '0, pend_sel = '0;
    logic         pend_sel_we = 1'b0;

    task automatic tick();
        @(posedge clk);
        fiq_m = |((hw_req | sw_req) & en_m &  sel_m);
        irq_m = |((hw_req | sw_req) & en_m & ~sel_m);
        en_m  = (en_m | pend_set) & ~pend_clr;
        if (pend_sel_we) sel_m = pend_sel;
        pend_set = '0; pend_clr = '0; pend_sel_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [N-1:0] d);
        addr = a; wdata = d; wr = 1'b1;
        if (a == 8'h10) pend_set = d;
        if (a == 8'h14) pend_clr = d;
        if (a == 8'h0C) begin pend_sel = d; pend_sel_we = 1'b1; end
        tick();
        wr = 1'b0;
    endtask

    task automatic expect_read(input string tag, input logic [7:0] a, input logic [N-1:0] v);
        item_t it;
        addr = a;
        it.tag = tag; it.chk_rd = 1'b1; it.rd = v; it.fiq = fiq_m; it.irq = irq_m;
        q.push_back(it);
        #2;
    endtask

    task automatic expect_out(input string tag);
        item_t it;
        it.tag = tag; it.chk_rd = 1'b0; it.rd = '0; it.fiq = fiq_m; it.irq = irq_m;
        q.push_back(it);
        #2;
    endtask

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            item_t it;
            wait (q.size() > 0);
            #1;
            it = q.pop_front();
            checks++;
            if (it.chk_rd && rdata !== it.rd) begin
                errors++;
                $display("FAIL %s: rdata actual %h expected %h", it.tag, rdata, it.rd);
            end else if (fiq !== it.fiq || irq !== it.irq) begin
                errors++;
                $display("FAIL %s: fiq/irq actual %b/%b expected %b/%b",
                         it.tag, fiq, irq, it.fiq, it.irq);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: reset state
        expect_out("R6 outputs low");
        expect_read("R6 enable zero", 8'h10, 32'h0);
        expect_read("R6 select zero", 8'h0C, 32'h0);

        // R1: raw view from both paths, masked lines do not reach outputs
        hw_req = 32'h0000_00F0; sw_req = 32'h0300_0000;
        tick();
        expect_read("R1 raw hw|sw", 8'h08, 32'h0300_00F0);
        expect_out("R7 masked lines silent");

        // R3/R2: set-only writes
        bus_write(8'h10, 32'h0000_0030);
        expect_read("R2 enable read", 8'h10, 32'h0000_0030);
        expect_out("R8 no change same cycle as mask write");
        bus_write(8'h10, 32'h0000_0100);
        expect_read("R3 zeros keep bits", 8'h10, 32'h0000_0130);
        tick();
        expect_out("R7 normal line routed to irq");

        // R5: select word
        bus_write(8'h0C, 32'h0000_0010);
        expect_read("R5 select read", 8'h0C, 32'h0000_0010);
        tick();
        expect_out("R7 both outputs active");

        // R4: clear-only writes
        bus_write(8'h14, 32'h0000_0020);
        expect_read("R4 clear one bit", 8'h10, 32'h0000_0110);
        expect_read("R4 clear offset reads zero", 8'h14, 32'h0);
        tick();
        expect_out("R4 cleared line leaves irq");

        // R8: latency after request drop
        hw_req = '0;
        expect_out("R8 output holds before edge");
        tick();
        expect_out("R8 output drops after edge");

        // R1: software path alone
        sw_req = 32'h0000_0010;
        tick();
        expect_read("R1 raw sw only", 8'h08, 32'h0000_0010);
        tick();
        expect_out("R7 software request on fiq");

        // R9: unmapped offsets
        bus_write(8'h1C, 32'hFFFF_FFFF);
        bus_write(8'h00, 32'hFFFF_FFFF);
        expect_read("R9 enable untouched", 8'h10, 32'h0000_0110);
        expect_read("R9 select untouched", 8'h0C, 32'h0000_0010);
        expect_read("R9 unmapped reads zero", 8'h1C, 32'h0);
        expect_read("R9 offset zero reads zero", 8'h00, 32'h0);

        // R4: clear everything
        bus_write(8'h14, 32'hFFFF_FFFF);
        expect_read("R4 all cleared", 8'h10, 32'h0);
        tick();
        expect_out("R4 outputs off after full clear");

        // R7: alternating select over full word
        sw_req = '0;
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h0C, 32'hAAAA_AAAA);
        hw_req = 32'h5555_5555;
        tick();
        expect_out("R7 even lines to irq");
        hw_req = 32'hAAAA_0000;
        tick();
        expect_read("R1 raw upper odd lines", 8'h08, 32'hAAAA_0000);
        expect_out("R7 odd lines to fiq");
        hw_req = 32'h8000_0001;
        tick();
        expect_out("R7 top and bottom lines split");

        wait (q.size() == 0);
        #5;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule